// File: doc/BRIEF.md
# Address-Latched 4K x 1 Static Memory

This block is a cycle-level model of a 4096-word by 1-bit static memory. Every access cycle begins when chip enable (`ce_n`, active low) is seen going low. At that clock edge the 12-bit address is captured into an internal address register. From then on, the address pins are don't-care until the cycle ends. The stored bits sit in a 64 x 64 cell matrix. The row index is built from address bits 0-2 and 6-8, and the column index from bits 3-5 and 9-11.

Write data passes through an input latch that follows `din` while write enable (`we_n`, active low) is low inside an enabled cycle. The latch freezes when `we_n` or `ce_n` rises, and the frozen bit is then committed to the captured address. A read cycle has `we_n` high at the starting edge. The addressed bit is loaded into an output latch and driven for as long as `ce_n` stays low. The three-state output is modelled as a data value `dout` plus a drive flag `dout_en`. While the flag is low, `dout` reads 0, so several such memories can share a line in a wider array.

All inputs are sampled on `clk`. The asynchronous reset `rst_n` is released through a two-stage synchronizer, so the block leaves reset two rising edges after `rst_n` goes high. Cell contents are never cleared and need no refresh.

Top module: `lat_ram_4kx1`

## Requirements
- R1: Each of the 4096 addresses holds its own bit. Writing every address and then reading every address back returns the bit last written to each one.
- R2: The address used by a cycle is the value on `addr` at the first rising edge where `ce_n` is low after being high. Changing `addr` later in the same cycle affects neither the bit read nor the cell written.
- R3: While a write is pending or being committed, `dout_en` is 0. In a cycle that starts with `we_n` low, `dout_en` stays 0 throughout.
- R4: In a read cycle, `dout_en` is 1 and `dout` equals the stored bit from the clock edge after the starting edge. Both hold while `ce_n` stays low and `we_n` stays high. `dout_en` returns to 0 at the first edge where `ce_n` is sampled high.
- R5: The write data is the last `din` value sampled while `we_n` and `ce_n` were both low. Changes on `din` after `we_n` rises have no effect on the stored bit.
- R6: While `ce_n` is high, the block is idle. Activity on `we_n`, `din` and `addr` changes no stored bit and leaves `dout_en` at 0.
- R7: If `we_n` goes low during a read cycle, the output is released (`dout_en` 0 at the next edge). The latched `din` is then written to the address captured at the start of that cycle.
- R8: After reset, `dout_en` is 0 and `dout` is 0.
- R9: Stored bits are kept through any number of idle cycles without refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 12 | Word address, captured at the start of a cycle |
| ce_n | input | 1 | Chip enable, active low; its falling edge starts a cycle |
| we_n | input | 1 | Write enable, active low |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit; 0 while not driven |
| dout_en | output | 1 | 1 when the output is driven, 0 for high impedance |

## Verification
A wrong captured address shows at the ports one cycle later. The read in that cycle, or a read of the cell a write should have hit, returns the bit of another cell. To catch this, the bench moves the address pins right after every starting edge. A stuck write-data latch or a lost commit appears on the next read of that address. A faulty output flag appears within one clock of the starting edge or of `ce_n` rising, because the bench samples `dout_en` at each of those points.

// File: rtl/lat_ram_pkg.sv
package lat_ram_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned ROW_W  = ADDR_W / 2;
  localparam int unsigned COL_W  = ADDR_W - ROW_W;
endpackage

// File: rtl/lat_ram_addr_reg.sv
module lat_ram_addr_reg #(
  parameter int unsigned AW = lat_ram_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [AW-1:0]     addr_in,
  output logic [AW/2-1:0]   pin_row,
  output logic [AW/2-1:0]   pin_col,
  output logic [AW/2-1:0]   held_row,
  output logic [AW/2-1:0]   held_col
);
  localparam int unsigned GW = AW / 4;

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (capture) addr_d = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  // row = groups 0 and 2, column = groups 1 and 3
  for (genvar g = 0; g < GW; g++) begin : g_split
    assign pin_row[g]       = addr_in[g];
    assign pin_row[GW+g]    = addr_in[2*GW+g];
    assign pin_col[g]       = addr_in[GW+g];
    assign pin_col[GW+g]    = addr_in[3*GW+g];
    assign held_row[g]      = addr_q[g];
    assign held_row[GW+g]   = addr_q[2*GW+g];
    assign held_col[g]      = addr_q[GW+g];
    assign held_col[GW+g]   = addr_q[3*GW+g];
  end
endmodule

// File: rtl/lat_ram_din_latch.sv
module lat_ram_din_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic follow,
  input  logic close,
  input  logic d,
  output logic q,
  output logic pend,
  output logic commit
);
  logic q_r, q_d;
  logic pend_r, pend_d;

  assign commit = pend_r & close;

  always_comb begin
    q_d    = q_r;
    pend_d = pend_r;
    if (follow) begin
      q_d    = d;
      pend_d = 1'b1;
    end else if (commit) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r    <= 1'b0;
      pend_r <= 1'b0;
    end else begin
      q_r    <= q_d;
      pend_r <= pend_d;
    end
  end

  assign q    = q_r;
  assign pend = pend_r;

  // R5
  commit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !pend);
  // R5
  frozen_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !follow |=> $stable(q));
endmodule

// File: rtl/lat_ram_array.sv
module lat_ram_array #(
  parameter int unsigned RW = lat_ram_pkg::ROW_W,
  parameter int unsigned CW = lat_ram_pkg::COL_W
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_row,
  input  logic [CW-1:0] wr_col,
  input  logic          wr_bit,
  input  logic [RW-1:0] rd_row,
  input  logic [CW-1:0] rd_col,
  output logic          rd_bit
);
  localparam int unsigned ROWS = 1 << RW;
  localparam int unsigned COLS = 1 << CW;

  logic [ROWS-1:0][COLS-1:0] cells;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] row_q;
    logic            row_we;
    assign row_we = wr_en && (wr_row == RW'(r));
    always_ff @(posedge clk) begin
      if (row_we) row_q[wr_col] <= wr_bit;
    end
    assign cells[r] = row_q;
  end

  assign rd_bit = cells[rd_row][rd_col];
endmodule

// File: rtl/lat_ram_dout_stage.sv
module lat_ram_dout_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic start,
  input  logic rd_bit,
  output logic dout,
  output logic dout_en
);
  logic q_r, q_d;
  logic en_r, en_d;

  always_comb begin
    q_d  = q_r;
    en_d = en_r;
    if (start && we_n) q_d = rd_bit;
    if (ce_n)          en_d = 1'b0;
    else if (start)    en_d = we_n;
    else if (!we_n)    en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r  <= 1'b0;
      en_r <= 1'b0;
    end else begin
      q_r  <= q_d;
      en_r <= en_d;
    end
  end

  assign dout    = q_r & en_r;
  assign dout_en = en_r;

  // R4
  release_on_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dout_en);
  // R6
  drive_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !$past(ce_n));
  // R4
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && !ce_n && we_n && !start) |=> (dout_en && $stable(dout)));
endmodule

// File: rtl/lat_ram_4kx1.sv
module lat_ram_4kx1 #(
  parameter int unsigned ADDR_W = lat_ram_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              din,
  output logic              dout,
  output logic              dout_en
);
  localparam int unsigned RW = ADDR_W / 2;
  localparam int unsigned CW = ADDR_W - RW;

  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic ce_q;
  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) ce_q <= 1'b1;
    else         ce_q <= ce_n;
  end

  logic start;
  assign start = ce_q & ~ce_n;

  logic [RW-1:0] pin_row, held_row;
  logic [CW-1:0] pin_col, held_col;

  lat_ram_addr_reg #(.AW(ADDR_W)) i_addr (
    .clk      (clk),
    .rst_n    (rst_s2),
    .capture  (start),
    .addr_in  (addr),
    .pin_row  (pin_row),
    .pin_col  (pin_col),
    .held_row (held_row),
    .held_col (held_col)
  );

  logic wd_bit, wd_pend, wd_commit;
  lat_ram_din_latch i_din (
    .clk    (clk),
    .rst_n  (rst_s2),
    .follow (~ce_n & ~we_n),
    .close  (ce_n | we_n),
    .d      (din),
    .q      (wd_bit),
    .pend   (wd_pend),
    .commit (wd_commit)
  );

  logic rd_bit;
  lat_ram_array #(.RW(RW), .CW(CW)) i_array (
    .clk    (clk),
    .wr_en  (wd_commit),
    .wr_row (held_row),
    .wr_col (held_col),
    .wr_bit (wd_bit),
    .rd_row (pin_row),
    .rd_col (pin_col),
    .rd_bit (rd_bit)
  );

  lat_ram_dout_stage i_dout (
    .clk     (clk),
    .rst_n   (rst_s2),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .start   (start),
    .rd_bit  (rd_bit),
    .dout    (dout),
    .dout_en (dout_en)
  );

  // R3
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    wd_pend |-> !dout_en);
  // R2
  addr_held_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    (!ce_n && !ce_q) |=> ($stable(held_row) && $stable(held_col)));
  // R6
  idle_data_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    (ce_n && !wd_pend) |=> !wd_commit);
endmodule

// File: tb/test_lat_ram_4kx1.sv
module test_lat_ram_4kx1;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic ce_n = 1'b1;
  logic we_n = 1'b1;
  logic din = 1'b0;
  logic dout, dout_en;

  int tests = 0;
  int fails = 0;
  bit ref_mem [4096];

  always #5 clk = ~clk;

  lat_ram_4kx1 i_lat_ram_4kx1 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n),
    .we_n(we_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] other(input logic [11:0] a);
    return a ^ 12'hFFF;
  endfunction

  // write cycle; optionally scramble pins mid-cycle and change din after we_n rises
  task automatic do_write(input logic [11:0] a, input bit d, input string req);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    chk(dout_en == 1'b0, "R3", dout_en, 0);
    addr = other(a);
    @(negedge clk); we_n = 1'b1; din = ~d;
    chk(dout_en == 1'b0, req, dout_en, 0);
    @(negedge clk); ce_n = 1'b1; addr = $urandom;
    @(negedge clk);
    ref_mem[a] = d;
  endtask

  task automatic do_read(input logic [11:0] a, input string req);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b1; addr = a;
    @(negedge clk);
    chk(dout_en == 1'b1, "R4", dout_en, 1);
    chk(dout == ref_mem[a], req, dout, ref_mem[a]);
    addr = other(a);
    @(negedge clk);
    chk(dout == ref_mem[a] && dout_en, "R2", dout, ref_mem[a]);
    ce_n = 1'b1;
    @(negedge clk);
    chk(dout_en == 1'b0 && dout == 1'b0, "R4", dout_en, 0);
  endtask

  initial begin : watchdog
    #1_900_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dout_en == 1'b0 && dout == 1'b0, "R8", dout_en, 0);

    // R1: fill every address with random data, then read all back
    for (int i = 0; i < 4096; i++) do_write(12'(i), 1'($urandom), "R1");
    for (int i = 0; i < 4096; i++) do_read(12'(i), "R1");

    // R2 directed: address pattern that differs only in row / only in column fields
    do_write(12'h007, 1'b1, "R2");
    do_write(12'h038, 1'b0, "R2");
    do_read(12'h007, "R2");
    do_read(12'h038, "R2");
    do_read(other(12'h007), "R2");

    // R5: din toggling after we_n rise is covered in do_write; read back
    do_write(12'hA5A, 1'b1, "R5");
    do_read(12'hA5A, "R5");
    do_write(12'hA5A, 1'b0, "R5");
    do_read(12'hA5A, "R5");

    // R7: late write inside a read cycle
    begin
      logic [11:0] a;
      bit d;
      a = 12'h3C3;
      d = ~ref_mem[a];
      @(negedge clk); ce_n = 1'b0; we_n = 1'b1; addr = a;
      @(negedge clk);
      chk(dout_en == 1'b1 && dout == ref_mem[a], "R7", dout, ref_mem[a]);
      addr = other(a); we_n = 1'b0; din = d;
      @(negedge clk);
      chk(dout_en == 1'b0, "R7", dout_en, 0);
      we_n = 1'b1; din = ~d;
      @(negedge clk); ce_n = 1'b1;
      @(negedge clk);
      ref_mem[a] = d;
      do_read(a, "R7");
      do_read(other(a), "R7");
    end

    // R6: idle activity must not disturb contents or output
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'($urandom); din = 1'($urandom); addr = 12'($urandom);
      if (k % 8 == 7) chk(dout_en == 1'b0, "R6", dout_en, 0);
    end
    @(negedge clk); we_n = 1'b1;
    for (int k = 0; k < 64; k++) do_read(12'($urandom), "R6");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [11:0] a;
      a = 12'($urandom);
      if ($urandom % 2) do_write(a, 1'($urandom), "R1");
      else              do_read(a, "R1");
    end

    // R9: long idle, then read back
    repeat (2000) @(negedge clk);
    for (int k = 0; k < 200; k++) do_read(12'($urandom), "R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule